// File: doc/BRIEF.md
# Debug Register Target for a Processor Core

This block sits next to a processor core and serves a small debug request port. An external sequencer issues requests that carry a 4-bit register address, a write flag and 64-bit write data. The block answers each request with a one-cycle acknowledge, and for reads it returns 64-bit data in that same cycle. Through this port the sequencer can halt the core, let it run again, or release it for exactly one instruction. It can also read the core's state: the next instruction address, the machine state register, the condition register, the packed fixed-point exception flags and any of the 32 general registers. A general register is read in two steps: the sequencer first writes its index, then reads a data register.

Two state machines do the work. The handshake machine has three states. `XS_IDLE` moves to `XS_RESP` when a request is seen. `XS_RESP` drives acknowledge for one cycle, and any write commits at the end of that cycle. It then always moves to `XS_WAIT_LOW`, which returns to `XS_IDLE` once the request line is sampled low. The core-control machine also has three states. `CS_RUN` moves to `CS_HALTED` on a stop command. `CS_HALTED` moves to `CS_STEPPING` on a step command, or to `CS_RUN` on a resume command. `CS_STEPPING` moves back to `CS_HALTED` when the core reports a retired instruction, or to `CS_RUN` on resume. A stop command leads to `CS_HALTED` from every state.

Top module: `dbg_regport`

## Requirements
- R1: Acknowledge goes high for exactly one cycle, in the cycle after a request is sampled in the idle state. No further acknowledge is given until the request line has been sampled low for at least one cycle.
- R2: For a read, `rdata_o` carries the addressed value in the acknowledge cycle. At all other times, and on write acknowledges, it is zero.
- R3: A write to address 0 with bit 0 set raises `halt_o`. From then on, status address 1 reads 2: bit 1 (weight 2) is 1 while halted, and all other status bits are 0.
- R4: A write to address 0 with bit 3 set while halted drops `halt_o` and raises `step_o` until `retire_i` is seen high. The cycle after that, `halt_o` is high again, `step_o` is low, and status reads 2. While stepping, status reads 0.
- R5: A write to address 0 with bit 1 set (and bit 0 clear) lowers `halt_o` and `step_o`. Status then reads 0.
- R6: Address 2 reads `nia_i`, address 3 reads `msr_i`, and address 8 reads `cr_i`.
- R7: A write to address 4 loads bits 4:0 of the write data into `gpr_idx_o`. A read of address 5 returns `gpr_data_i`. The index changes on no other access.
- R8: Address 9 reads the exception flags packed as SO in bit 0, CA in bit 2, CA32 in bit 3, OV in bit 4 and OV32 in bit 5. All other bits are 0.
- R9: Reads of addresses 6, 7 and 10 through 15 return zero. Writes to them change neither `halt_o`, `step_o` nor `gpr_idx_o`.
- R10: After reset, `halt_o`, `step_o` and `ack_o` are low, `gpr_idx_o` is 0, and status reads 0.
- R11: Within one control word, stop (bit 0) takes priority over step (bit 3), and step takes priority over resume (bit 1). A step command while running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request, held until acknowledged |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 64 | Write data |
| ack_o | output | 1 | One-cycle acknowledge |
| rdata_o | output | 64 | Read data, valid with acknowledge |
| halt_o | output | 1 | Stop request to the core |
| step_o | output | 1 | High while the core may retire one instruction |
| retire_i | input | 1 | Core retired an instruction |
| nia_i | input | 64 | Next instruction address |
| msr_i | input | 64 | Machine state register |
| cr_i | input | 64 | Condition register |
| xer_so_i | input | 1 | Summary overflow flag |
| xer_ca_i | input | 1 | Carry flag |
| xer_ca32_i | input | 1 | 32-bit carry flag |
| xer_ov_i | input | 1 | Overflow flag |
| xer_ov32_i | input | 1 | 32-bit overflow flag |
| gpr_idx_o | output | 5 | General register read index |
| gpr_data_i | input | 64 | General register value at that index |

## Verification
A table of reads and writes covers each mapped address with distinct core values. The flag pattern has some flags set and some clear, so a misplaced bit in the packing shows up. Index writes use several values, including one with bits above bit 4 set, which shows whether the index is truncated correctly and whether the data port follows the index. Directed sequences run stop, step, retire and resume. They check the handshake's one-pulse behaviour under a held request, the stop-over-step priority, a step issued while running, and writes to unmapped addresses.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    typedef enum logic [1:0] {XS_IDLE, XS_RESP, XS_WAIT_LOW} xact_state_e;
    typedef enum logic [1:0] {CS_RUN, CS_HALTED, CS_STEPPING} core_state_e;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
    localparam logic [ADDR_W-1:0] A_NIA  = 4'd2;
    localparam logic [ADDR_W-1:0] A_MSR  = 4'd3;
    localparam logic [ADDR_W-1:0] A_GIDX = 4'd4;
    localparam logic [ADDR_W-1:0] A_GDAT = 4'd5;
    localparam logic [ADDR_W-1:0] A_CR   = 4'd8;
    localparam logic [ADDR_W-1:0] A_XER  = 4'd9;

    localparam int unsigned CTL_STOP    = 0;
    localparam int unsigned CTL_RESUME  = 1;
    localparam int unsigned CTL_STEP    = 3;
    localparam int unsigned STAT_HALTED = 1;
endpackage

// File: rtl/dbg_xact_fsm.sv
module dbg_xact_fsm
    import dbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic ack_o
);
    xact_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:     if (req_i) state_d = XS_RESP;
            XS_RESP:     state_d = XS_WAIT_LOW;
            XS_WAIT_LOW: if (!req_i) state_d = XS_IDLE;
            default:     state_d = XS_IDLE;
        endcase
    end

    always_comb begin
        ack_o = (state_q == XS_RESP);
    end

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R1
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_i)); // R1
endmodule

// File: rtl/dbg_run_ctl.sv
module dbg_run_ctl
    import dbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic stop_bit,
    input  logic resume_bit,
    input  logic step_bit,
    input  logic retire_i,
    output logic halt_o,
    output logic step_o,
    output logic halted_o
);
    core_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN: begin
                if (ctl_we && stop_bit) state_d = CS_HALTED;
            end
            CS_HALTED: begin
                if (ctl_we) begin
                    if (stop_bit)        state_d = CS_HALTED;
                    else if (step_bit)   state_d = CS_STEPPING;
                    else if (resume_bit) state_d = CS_RUN;
                end
            end
            CS_STEPPING: begin
                if (ctl_we && stop_bit)        state_d = CS_HALTED;
                else if (ctl_we && resume_bit) state_d = CS_RUN;
                else if (retire_i)             state_d = CS_HALTED;
            end
            default: state_d = CS_RUN;
        endcase
    end

    always_comb begin
        halt_o   = (state_q == CS_HALTED);
        step_o   = (state_q == CS_STEPPING);
        halted_o = (state_q == CS_HALTED);
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && stop_bit) |=> (halt_o && !step_o)); // R3
    AST_STEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && retire_i && !ctl_we) |=> (halt_o && !step_o)); // R4
    AST_RESUME_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && resume_bit && !stop_bit) |=> !halt_o); // R5
endmodule

// File: rtl/dbg_reg_view.sv
module dbg_reg_view
    import dbg_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned GPR_CNT = 32,
    localparam int unsigned IDX_W  = $clog2(GPR_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              halted_i,
    input  logic [DATA_W-1:0] nia_i,
    input  logic [DATA_W-1:0] msr_i,
    input  logic [DATA_W-1:0] cr_i,
    input  logic [4:0]        xer_flags_i,
    input  logic [DATA_W-1:0] gpr_data_i,
    output logic [IDX_W-1:0]  gpr_idx_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] stat_word, xer_word, sel_word;

    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata_i[IDX_W-1:0];
    end

    assign gpr_idx_o = idx_q;

    always_comb begin
        stat_word = '0;
        stat_word[STAT_HALTED] = halted_i;
        xer_word    = '0;
        xer_word[0] = xer_flags_i[0];
        xer_word[2] = xer_flags_i[1];
        xer_word[3] = xer_flags_i[2];
        xer_word[4] = xer_flags_i[3];
        xer_word[5] = xer_flags_i[4];
    end

    always_comb begin
        unique case (addr_i)
            A_STAT:  sel_word = stat_word;
            A_NIA:   sel_word = nia_i;
            A_MSR:   sel_word = msr_i;
            A_GDAT:  sel_word = gpr_data_i;
            A_CR:    sel_word = cr_i;
            A_XER:   sel_word = xer_word;
            default: sel_word = '0;
        endcase
        rdata_o = rd_en ? sel_word : '0;
    end

    AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_we |=> $stable(gpr_idx_o)); // R7
endmodule

// File: rtl/dbg_regport.sv
module dbg_regport
    import dbg_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned GPR_CNT = 32,
    localparam int unsigned IDX_W  = $clog2(GPR_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [3:0]        addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              halt_o,
    output logic              step_o,
    input  logic              retire_i,
    input  logic [DATA_W-1:0] nia_i,
    input  logic [DATA_W-1:0] msr_i,
    input  logic [DATA_W-1:0] cr_i,
    input  logic              xer_so_i,
    input  logic              xer_ca_i,
    input  logic              xer_ca32_i,
    input  logic              xer_ov_i,
    input  logic              xer_ov32_i,
    output logic [IDX_W-1:0]  gpr_idx_o,
    input  logic [DATA_W-1:0] gpr_data_i
);
    logic ack, commit_we, ctl_we, idx_we, rd_en, halted;

    dbg_xact_fsm u_xact (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .ack_o (ack)
    );

    assign commit_we = ack && wr_i;
    assign ctl_we    = commit_we && (addr_i == A_CTRL);
    assign idx_we    = commit_we && (addr_i == A_GIDX);
    assign rd_en     = ack && !wr_i;
    assign ack_o     = ack;

    dbg_run_ctl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .stop_bit   (wdata_i[CTL_STOP]),
        .resume_bit (wdata_i[CTL_RESUME]),
        .step_bit   (wdata_i[CTL_STEP]),
        .retire_i   (retire_i),
        .halt_o     (halt_o),
        .step_o     (step_o),
        .halted_o   (halted)
    );

    dbg_reg_view #(.DATA_W(DATA_W), .GPR_CNT(GPR_CNT)) u_view (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_we      (idx_we),
        .wdata_i     (wdata_i),
        .rd_en       (rd_en),
        .addr_i      (addr_i),
        .halted_i    (halted),
        .nia_i       (nia_i),
        .msr_i       (msr_i),
        .cr_i        (cr_i),
        .xer_flags_i ({xer_ov32_i, xer_ov_i, xer_ca32_i, xer_ca_i, xer_so_i}),
        .gpr_data_i  (gpr_data_i),
        .gpr_idx_o   (gpr_idx_o),
        .rdata_o     (rdata_o)
    );

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (rdata_o == '0)); // R2
    AST_UNMAPPED_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && wr_i && addr_i != A_CTRL && !halt_o && !step_o) |=> (!halt_o && !step_o)); // R9
endmodule

// File: tb/dbg_regport_bench.sv
module dbg_regport_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        wr_i = 1'b0;
    logic [63:0] wdata_i = '0;
    logic        ack_o;
    logic [63:0] rdata_o;
    logic        halt_o, step_o;
    logic        retire_i = 1'b0;
    logic [4:0]  gpr_idx_o;
    logic [63:0] gpr_data_i;

    localparam logic [63:0] NIA = 64'h0000_0000_0001_2340;
    localparam logic [63:0] MSR = 64'h8000_0000_0000_1033;
    localparam logic [63:0] CRV = 64'h0000_0000_2468_ACE0;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign gpr_data_i = 64'hC0DE_0000_0000_0000 | ({59'd0, gpr_idx_o} << 8) | {59'd0, gpr_idx_o};

    dbg_regport u_dbg_regport (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o), .halt_o(halt_o),
        .step_o(step_o), .retire_i(retire_i), .nia_i(NIA), .msr_i(MSR), .cr_i(CRV),
        .xer_so_i(1'b1), .xer_ca_i(1'b0), .xer_ca32_i(1'b1), .xer_ov_i(1'b1),
        .xer_ov32_i(1'b0), .gpr_idx_o(gpr_idx_o), .gpr_data_i(gpr_data_i)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic        wr;
        logic [63:0] wdata;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b0, 64'd0,    NIA},                    // R6
        '{4'd3,  1'b0, 64'd0,    MSR},                    // R6
        '{4'd8,  1'b0, 64'd0,    CRV},                    // R6
        '{4'd9,  1'b0, 64'd0,    64'h19},                 // R8
        '{4'd4,  1'b1, 64'd7,    64'd0},                  // R7
        '{4'd5,  1'b0, 64'd0,    64'hC0DE_0000_0000_0707},// R7
        '{4'd4,  1'b1, 64'd31,   64'd0},                  // R7
        '{4'd5,  1'b0, 64'd0,    64'hC0DE_0000_0000_1F1F},// R7
        '{4'd6,  1'b0, 64'd0,    64'd0},                  // R9
        '{4'd15, 1'b0, 64'd0,    64'd0},                  // R9
        '{4'd4,  1'b1, 64'h25,   64'd0},                  // R7
        '{4'd5,  1'b0, 64'd0,    64'hC0DE_0000_0000_0505} // R7
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic [3:0] a, input logic w, input logic [63:0] d,
                        output logic [63:0] rd, output int lat);
        addr_i = a; wr_i = w; wdata_i = d; req_i = 1'b1;
        lat = 0;
        rd = '0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            lat++;
            if (ack_o) begin
                rd = rdata_o;
                break;
            end
        end
        req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] rd;
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R10 halt", {63'd0, halt_o}, 64'd0);
        chk("R10 step", {63'd0, step_o}, 64'd0);
        chk("R10 ack", {63'd0, ack_o}, 64'd0);
        chk("R10 idx", {59'd0, gpr_idx_o}, 64'd0);
        xact(4'd1, 1'b0, 64'd0, rd, lat);
        chk("R10 status", rd, 64'd0);
        chk("R1 latency", lat, 1);

        for (int k = 0; k < NV; k++) begin
            xact(VEC[k].addr, VEC[k].wr, VEC[k].wdata, rd, lat);
            chk($sformatf("R2/R6-R9 vec%0d", k), rd, VEC[k].exp);
            chk("R1 vec latency", lat, 1);
        end
        chk("R7 idx truncated", {59'd0, gpr_idx_o}, 64'd5);

        // R1: held request gets one acknowledge only
        addr_i = 4'd2; wr_i = 1'b0; req_i = 1'b1;
        begin
            int acks = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (ack_o) acks++;
            end
            chk("R1 single ack under held req", acks, 1);
        end
        req_i = 1'b0;
        @(negedge clk); @(negedge clk);

        // R3 stop
        xact(4'd0, 1'b1, 64'h1, rd, lat);
        chk("R3 halt", {63'd0, halt_o}, 64'd1);
        xact(4'd1, 1'b0, 64'd0, rd, lat);
        chk("R3 status", rd, 64'd2);

        // R11 stop beats step
        xact(4'd0, 1'b1, 64'h9, rd, lat);
        chk("R11 stop over step halt", {63'd0, halt_o}, 64'd1);
        chk("R11 stop over step step", {63'd0, step_o}, 64'd0);

        // R4 step
        xact(4'd0, 1'b1, 64'h8, rd, lat);
        chk("R4 step halt low", {63'd0, halt_o}, 64'd0);
        chk("R4 step_o high", {63'd0, step_o}, 64'd1);
        xact(4'd1, 1'b0, 64'd0, rd, lat);
        chk("R4 status stepping", rd, 64'd0);
        retire_i = 1'b1;
        @(negedge clk);
        retire_i = 1'b0;
        chk("R4 rehalt", {63'd0, halt_o}, 64'd1);
        chk("R4 step_o low", {63'd0, step_o}, 64'd0);
        xact(4'd1, 1'b0, 64'd0, rd, lat);
        chk("R4 status rehalted", rd, 64'd2);

        // R11 step over resume
        xact(4'd0, 1'b1, 64'hA, rd, lat);
        chk("R11 step over resume", {62'd0, step_o, halt_o}, 64'd2);
        retire_i = 1'b1;
        @(negedge clk);
        retire_i = 1'b0;

        // R5 resume
        xact(4'd0, 1'b1, 64'h2, rd, lat);
        chk("R5 halt low", {63'd0, halt_o}, 64'd0);
        xact(4'd1, 1'b0, 64'd0, rd, lat);
        chk("R5 status", rd, 64'd0);

        // R11 step while running ignored
        xact(4'd0, 1'b1, 64'h8, rd, lat);
        chk("R11 step ignored running", {62'd0, step_o, halt_o}, 64'd0);

        // R9 unmapped writes ignored
        xact(4'd6, 1'b1, 64'h1, rd, lat);
        chk("R9 write 6 no halt", {62'd0, step_o, halt_o}, 64'd0);
        xact(4'd12, 1'b1, 64'hF, rd, lat);
        chk("R9 write 12 no halt", {62'd0, step_o, halt_o}, 64'd0);
        chk("R9 idx untouched", {59'd0, gpr_idx_o}, 64'd5);
        chk("R2 write ack data zero", rd, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule